// File: doc/BRIEF.md
# Reset Exception Sequencer

This block steers a 32-bit processor core from the instant its synchronous reset is applied until the first instruction has been started. While reset is high it drops whatever was in progress and forces the architectural control state to its power-on values: a 16-bit status register with supervisor mode on, tracing off, the master/interrupt-state flag off and the interrupt mask at its top level, a zeroed vector base register, and disabled local-memory configurations.

Once reset falls, the sequencer lets a fixed settling window elapse and watches a debug breakpoint request throughout it. If no breakpoint arrived, it reads the initial stack pointer and then the initial program counter over a word-wide valid/ready read port. It then pulses a start strobe to the fetch unit with the loaded program counter. A bus error on either read, or a fault reported at any time between reset release and completion of the first instruction, locks the sequencer into a fault-on-fault halt. A breakpoint seen in the window locks it into a debug halt instead. Only a new reset leaves either halt.

Top module: `reset_exc_seq`

## Requirements
- R1: The cycle after `rst` is sampled high (from any state, including mid-read and halted), `mem_req_valid`, `fetch_start`, `halted` and `halt_fault` are 0 and `sp_out` and `fetch_pc` read 0; a response still pending from before is discarded.
- R2: `sr_out` reads 16'h2700 after reset: bit 15 (trace) = 0, bit 13 (supervisor) = 1, bit 12 (master) = 0, bits 10:8 (interrupt mask) = 7.
- R3: `vbr_out` reads 0 and every bit of `lmem_en` reads 0 after reset.
- R4: After `rst` falls, exactly `WAIT_CYCLES` (default 80) rising edges with `rst` low pass with no read request; `mem_req_valid` rises right after the last of them.
- R5: If `dbg_brk` is high on any edge of the window, including its final edge, no read is ever requested and `halted`=1 with `halt_fault`=0; `dbg_brk` after the window has no effect.
- R6: The first read uses address 0 and its data goes to `sp_out`; the second uses address 4 and its data goes to `fetch_pc`. A request holds valid and address until `mem_req_ready` is seen, and data and error are used only in cycles with `mem_rsp_valid`=1.
- R7: After an error-free second response, `fetch_start` is high for exactly one cycle with `fetch_pc` equal to the loaded word.
- R8: `mem_rsp_err`=1 on a valid response to either read gives `halted`=1 and `halt_fault`=1, with no further request and no `fetch_start`.
- R9: `fault_in` high on any edge from reset release until `first_insn_done` has been seen gives `halted`=1 and `halt_fault`=1; after `first_insn_done`, `fault_in` has no effect.
- R10: Both halt states persist until `rst` is applied; reset then clears them and restarts the window from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high processor reset |
| dbg_brk | input | 1 | Debug breakpoint request sampled during the window |
| fault_in | input | 1 | Access or address fault reported by the core |
| first_insn_done | input | 1 | First instruction has completed |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Read address |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response word |
| mem_rsp_err | input | 1 | Read response carries an error |
| fetch_start | output | 1 | One-cycle start strobe to the fetch unit |
| fetch_pc | output | 32 | Loaded program counter |
| sp_out | output | 32 | Loaded stack pointer |
| sr_out | output | 16 | Status register |
| vbr_out | output | 32 | Vector base register |
| lmem_en | output | 2 | Local-memory enable bits |
| halted | output | 1 | Sequencer is halted |
| halt_fault | output | 1 | Halt was caused by a fault |

## Verification
The bench aims at the window edges: a breakpoint on its final edge must halt, one on the following edge must be ignored, and a design counting 79 or 81 cycles shifts the first request and is caught by the per-cycle model. Reset pulses are dropped into the middle of an outstanding read and into both halt states, where a design that kept the stale response or the sticky halt would load a wrong stack pointer or stay stopped. Responses arrive with random ready gaps and latency while the data and error lines carry junk outside valid cycles, so a design that captured early or read the error flag outside a response would load junk or halt. Faults are injected in the window, just before and just after the first instruction completes, separating the fault-on-fault halt from an ignored late fault.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    localparam int SR_W = 16;

    // Sequencer phases from reset release to the first instruction
    typedef enum logic [3:0] {
        ST_WINDOW,
        ST_SP_REQ,
        ST_SP_RSP,
        ST_PC_REQ,
        ST_PC_RSP,
        ST_LAUNCH,
        ST_FIRST,
        ST_RUN,
        ST_HALT_DBG,
        ST_HALT_FOF
    } seq_state_e;

    typedef struct packed {
        logic       trace;
        logic       supv;
        logic       master;
        logic [2:0] ipl;
    } sr_t;

    localparam sr_t SR_AT_RESET = '{trace: 1'b0, supv: 1'b1, master: 1'b0, ipl: 3'd7};

    function automatic logic [SR_W-1:0] sr_pack(input sr_t s);
        logic [SR_W-1:0] r;
        r       = '0;
        r[15]   = s.trace;
        r[13]   = s.supv;
        r[12]   = s.master;
        r[10:8] = s.ipl;
        return r;
    endfunction

endpackage

// File: rtl/rse_window_timer.sv
module rse_window_timer #(
    parameter int WAIT_CYCLES = 80
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic dbg_brk,
    output logic win_last,
    output logic brk_hit
);
    localparam int CW = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          brk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            brk_q <= 1'b0;
        end else if (run) begin
            if (cnt_q != LAST) cnt_q <= cnt_q + CW'(1);
            if (dbg_brk) brk_q <= 1'b1;
        end
    end

    assign win_last = run && (cnt_q == LAST);
    assign brk_hit  = brk_q || dbg_brk;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);                                          // R4
    AST_BRK_STICKY: assert property (@(posedge clk) disable iff (rst)
        brk_q |=> brk_q);                                        // R5

endmodule

// File: rtl/rse_arch_regs.sv
module rse_arch_regs
    import rst_seq_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int N_LMEM = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sp_load,
    input  logic              pc_load,
    input  logic [XLEN-1:0]   load_data,
    output logic [SR_W-1:0]   sr_out,
    output logic [XLEN-1:0]   vbr,
    output logic [N_LMEM-1:0] lmem_en,
    output logic [XLEN-1:0]   sp,
    output logic [XLEN-1:0]   pc
);
    sr_t               sr_q;
    logic [XLEN-1:0]   vbr_q;
    logic [N_LMEM-1:0] lmem_q;
    logic [XLEN-1:0]   sp_q;
    logic [XLEN-1:0]   pc_q;

    // Control state: only reset writes it inside this block
    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= SR_AT_RESET;
            vbr_q  <= '0;
            lmem_q <= '0;
        end
    end

    // Vector registers loaded from the read port
    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
            pc_q <= '0;
        end else begin
            if (sp_load) sp_q <= load_data;
            if (pc_load) pc_q <= load_data;
        end
    end

    assign sr_out  = sr_pack(sr_q);
    assign vbr     = vbr_q;
    assign lmem_en = lmem_q;
    assign sp      = sp_q;
    assign pc      = pc_q;

    AST_SR_HELD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(sr_q));                                 // R2

endmodule

// File: rtl/rse_seq_ctrl.sv
module rse_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int              XLEN    = 32,
    parameter logic [XLEN-1:0] SP_ADDR = '0,
    parameter logic [XLEN-1:0] PC_ADDR = XLEN'(4)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            win_last,
    input  logic            brk_hit,
    input  logic            fault_in,
    input  logic            first_done,
    input  logic            req_ready,
    input  logic            rsp_valid,
    input  logic            rsp_err,
    output logic            in_window,
    output logic            req_valid,
    output logic [XLEN-1:0] req_addr,
    output logic            sp_load,
    output logic            pc_load,
    output logic            fetch_start,
    output logic            halted,
    output logic            halt_fault
);
    seq_state_e state_q, state_d;
    logic       busy;

    // Exception processing is underway until the first instruction completes
    assign busy = (state_q != ST_RUN) && (state_q != ST_HALT_DBG) && (state_q != ST_HALT_FOF);

    always_comb begin
        state_d = state_q;
        sp_load = 1'b0;
        pc_load = 1'b0;
        if (busy && fault_in) begin
            state_d = ST_HALT_FOF;
        end else begin
            unique case (state_q)
                ST_WINDOW: if (win_last) state_d = brk_hit ? ST_HALT_DBG : ST_SP_REQ;
                ST_SP_REQ: if (req_ready) state_d = ST_SP_RSP;
                ST_SP_RSP: if (rsp_valid) begin
                    if (rsp_err) state_d = ST_HALT_FOF;
                    else begin
                        sp_load = 1'b1;
                        state_d = ST_PC_REQ;
                    end
                end
                ST_PC_REQ: if (req_ready) state_d = ST_PC_RSP;
                ST_PC_RSP: if (rsp_valid) begin
                    if (rsp_err) state_d = ST_HALT_FOF;
                    else begin
                        pc_load = 1'b1;
                        state_d = ST_LAUNCH;
                    end
                end
                ST_LAUNCH: state_d = ST_FIRST;
                ST_FIRST:  if (first_done) state_d = ST_RUN;
                default:   state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_WINDOW;
        else     state_q <= state_d;
    end

    assign in_window   = (state_q == ST_WINDOW);
    assign req_valid   = (state_q == ST_SP_REQ) || (state_q == ST_PC_REQ);
    assign req_addr    = (state_q == ST_PC_REQ) ? PC_ADDR : SP_ADDR;
    assign fetch_start = (state_q == ST_LAUNCH);
    assign halted      = (state_q == ST_HALT_DBG) || (state_q == ST_HALT_FOF);
    assign halt_fault  = (state_q == ST_HALT_FOF);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_addr));      // R6
    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        fetch_start |=> !fetch_start);                                    // R7
    AST_ERR_HALTS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SP_RSP || state_q == ST_PC_RSP) && rsp_valid && rsp_err
        |=> halted && halt_fault);                                        // R8
    AST_LATE_FAULT_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) && fault_in |=> !halted);                     // R9
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted && $stable(halt_fault));                        // R10

endmodule

// File: rtl/reset_exc_seq.sv
module reset_exc_seq
    import rst_seq_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter int              WAIT_CYCLES = 80,
    parameter int              N_LMEM      = 2,
    parameter logic [XLEN-1:0] SP_ADDR     = '0,
    parameter logic [XLEN-1:0] PC_ADDR     = XLEN'(4)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_brk,
    input  logic              fault_in,
    input  logic              first_insn_done,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [XLEN-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [XLEN-1:0]   mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              fetch_start,
    output logic [XLEN-1:0]   fetch_pc,
    output logic [XLEN-1:0]   sp_out,
    output logic [SR_W-1:0]   sr_out,
    output logic [XLEN-1:0]   vbr_out,
    output logic [N_LMEM-1:0] lmem_en,
    output logic              halted,
    output logic              halt_fault
);
    logic in_window;
    logic win_last;
    logic brk_hit;
    logic sp_load;
    logic pc_load;

    rse_window_timer #(
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (in_window),
        .dbg_brk  (dbg_brk),
        .win_last (win_last),
        .brk_hit  (brk_hit)
    );

    rse_seq_ctrl #(
        .XLEN    (XLEN),
        .SP_ADDR (SP_ADDR),
        .PC_ADDR (PC_ADDR)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .win_last    (win_last),
        .brk_hit     (brk_hit),
        .fault_in    (fault_in),
        .first_done  (first_insn_done),
        .req_ready   (mem_req_ready),
        .rsp_valid   (mem_rsp_valid),
        .rsp_err     (mem_rsp_err),
        .in_window   (in_window),
        .req_valid   (mem_req_valid),
        .req_addr    (mem_req_addr),
        .sp_load     (sp_load),
        .pc_load     (pc_load),
        .fetch_start (fetch_start),
        .halted      (halted),
        .halt_fault  (halt_fault)
    );

    rse_arch_regs #(
        .XLEN   (XLEN),
        .N_LMEM (N_LMEM)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .sp_load   (sp_load),
        .pc_load   (pc_load),
        .load_data (mem_rsp_data),
        .sr_out    (sr_out),
        .vbr       (vbr_out),
        .lmem_en   (lmem_en),
        .sp        (sp_out),
        .pc        (fetch_pc)
    );

    AST_FIRST_REQ_AFTER_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req_valid) && (mem_req_addr == SP_ADDR) |-> $past(win_last));  // R4

endmodule

// File: tb/test_reset_exc_seq.sv
module test_reset_exc_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT_N     = 80;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dbg_brk = 1'b0;
    logic        fault_in = 1'b0;
    logic        first_insn_done = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic        fetch_start;
    logic [31:0] fetch_pc;
    logic [31:0] sp_out;
    logic [15:0] sr_out;
    logic [31:0] vbr_out;
    logic [1:0]  lmem_en;
    logic        halted;
    logic        halt_fault;

    always #(CLK_PERIOD/2) clk = ~clk;

    reset_exc_seq i_reset_exc_seq (
        .clk(clk), .rst(rst), .dbg_brk(dbg_brk), .fault_in(fault_in),
        .first_insn_done(first_insn_done),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .fetch_start(fetch_start), .fetch_pc(fetch_pc), .sp_out(sp_out),
        .sr_out(sr_out), .vbr_out(vbr_out), .lmem_en(lmem_en),
        .halted(halted), .halt_fault(halt_fault)
    );

    int n_total = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural memory: ready gaps, latency, junk outside valid responses
    int          lat = 0;
    bit          rand_ready = 0;
    logic [31:0] sp_word = '0;
    logic [31:0] pc_word = '0;
    bit          err_sp = 0;
    bit          err_pc = 0;
    bit          pend = 0;
    int          wait_n = 0;
    logic [31:0] pend_addr = '0;

    always @(posedge clk) begin
        if (rst) pend = 0;
        else if (pend && mem_rsp_valid) pend = 0;
        else if (pend) begin
            if (wait_n > 0) wait_n--;
        end else if (mem_req_valid && mem_req_ready) begin
            pend = 1; wait_n = lat; pend_addr = mem_req_addr;
        end
    end

    always @(negedge clk) begin
        mem_rsp_valid = pend && (wait_n == 0);
        mem_rsp_data  = (pend && wait_n == 0) ? ((pend_addr == 32'h0) ? sp_word : pc_word) : 32'hDEAD_BEEF;
        mem_rsp_err   = (pend && wait_n == 0) ? ((pend_addr == 32'h0) ? err_sp : err_pc) : 1'b1;
        mem_req_ready = !pend && (rand_ready ? ($urandom_range(0, 1) == 1) : 1'b1);
    end

    // Reference model: phase 0 window, 1/2 stack read, 3/4 counter read,
    // 5 start, 6 awaiting first instruction, 7 running, 8 debug halt, 9 fault halt
    int          m_ph = 0;
    int          m_cnt = 0;
    bit          m_brk = 0;
    logic [31:0] m_sp = '0;
    logic [31:0] m_pc = '0;
    bit          live = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_brk = 0; m_sp = '0; m_pc = '0; live = 1;
        end else if (fault_in && m_ph <= 6) begin
            m_ph = 9;
        end else begin
            case (m_ph)
                0: begin
                    if (dbg_brk) m_brk = 1;
                    m_cnt++;
                    if (m_cnt == WAIT_N) m_ph = m_brk ? 8 : 1;
                end
                1: if (mem_req_ready) m_ph = 2;
                2: if (mem_rsp_valid) begin
                    if (mem_rsp_err) m_ph = 9;
                    else begin m_sp = mem_rsp_data; m_ph = 3; end
                end
                3: if (mem_req_ready) m_ph = 4;
                4: if (mem_rsp_valid) begin
                    if (mem_rsp_err) m_ph = 9;
                    else begin m_pc = mem_rsp_data; m_ph = 5; end
                end
                5: m_ph = 6;
                6: if (first_insn_done) m_ph = 7;
                default: ;
            endcase
        end
    end

    always @(negedge clk) begin
        if (live) begin
            chk(mem_req_valid == (m_ph == 1 || m_ph == 3), "R6 req_valid", 32'(mem_req_valid), 32'(m_ph == 1 || m_ph == 3));
            if (mem_req_valid)
                chk(mem_req_addr == ((m_ph == 3) ? 32'd4 : 32'd0), "R6 req_addr", mem_req_addr, (m_ph == 3) ? 32'd4 : 32'd0);
            chk(fetch_start == (m_ph == 5), "R7 fetch_start", 32'(fetch_start), 32'(m_ph == 5));
            chk(halted == (m_ph >= 8), "R10 halted", 32'(halted), 32'(m_ph >= 8));
            chk(halt_fault == (m_ph == 9), "R8 halt_fault", 32'(halt_fault), 32'(m_ph == 9));
            chk(sp_out == m_sp, "R6 sp_out", sp_out, m_sp);
            chk(fetch_pc == m_pc, "R7 fetch_pc", fetch_pc, m_pc);
            chk(sr_out == 16'h2700, "R2 sr_out", 32'(sr_out), 32'h2700);
            chk(vbr_out == 32'h0 && lmem_en == 2'b00, "R3 vbr/lmem", vbr_out | 32'(lmem_en), 32'h0);
        end
    end

    bit seen_req = 0;
    bit seen_start = 0;
    always @(negedge clk) begin
        if (mem_req_valid) seen_req = 1;
        if (fetch_start) seen_start = 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input int n);
        rst = 1'b1;
        tick(n);
        rst = 1'b0;
        seen_req = 0;
        seen_start = 0;
    endtask

    task automatic wait_start(input string tag);
        bit got;
        got = 0;
        for (int i = 0; i < 400 && !got; i++) begin
            @(negedge clk);
            got = fetch_start;
        end
        chk(got, tag, 32'(got), 32'd1);
    endtask

    task automatic count_window(input string tag);
        int cyc;
        cyc = 0;
        while (!mem_req_valid && cyc < 500) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == WAIT_N, tag, 32'(cyc), 32'(WAIT_N));
    endtask

    bit finished = 0;

    initial begin
        @(negedge clk);

        // Normal boot, always ready, zero latency
        sp_word = 32'h2000_0FF0; pc_word = 32'h0000_0400;
        do_reset(3);
        chk(!mem_req_valid && !halted && !fetch_start && sp_out == 0, "R1 reset state", 32'(halted), 32'h0);
        chk(sr_out == 16'h2700, "R2 status after reset", 32'(sr_out), 32'h2700);
        chk(vbr_out == 0 && lmem_en == 0, "R3 vbr and enables", vbr_out, 32'h0);
        count_window("R4 window length");
        wait_start("R7 start pulse");
        chk(fetch_pc == pc_word, "R7 pc at start", fetch_pc, pc_word);
        chk(sp_out == sp_word, "R6 sp loaded", sp_out, sp_word);
        tick(3); first_insn_done = 1; tick(1); first_insn_done = 0;
        tick(1); fault_in = 1; tick(1); fault_in = 0; tick(3);
        chk(!halted, "R9 fault after first instruction ignored", 32'(halted), 32'h0);

        // Random ready gaps and latency, then fault before first instruction
        rand_ready = 1; lat = 3; sp_word = 32'h0BAD_CAFE; pc_word = 32'h1234_5678;
        do_reset(2);
        wait_start("R6 start with slow memory");
        chk(sp_out == sp_word && fetch_pc == pc_word, "R6 both vectors", fetch_pc, pc_word);
        tick(2); fault_in = 1; tick(1); fault_in = 0; tick(1);
        chk(halted && halt_fault, "R9 fault before first instruction", 32'(halt_fault), 32'h1);
        tick(20);
        chk(halted, "R10 halt persists", 32'(halted), 32'h1);
        rand_ready = 0; lat = 0;
        do_reset(1);
        chk(!halted && !halt_fault, "R10 reset clears halt", 32'(halted), 32'h0);
        count_window("R10 window restarts");
        wait_start("R10 boot after halt");

        // Breakpoint in the middle of the window
        do_reset(2);
        tick(40); dbg_brk = 1; tick(1); dbg_brk = 0; tick(100);
        chk(halted && !halt_fault, "R5 breakpoint halt", 32'(halt_fault), 32'h0);
        chk(!seen_req, "R5 no fetch after breakpoint", 32'(seen_req), 32'h0);

        // Breakpoint on the final window edge
        do_reset(2);
        tick(WAIT_N - 1); dbg_brk = 1; tick(1); dbg_brk = 0;
        chk(halted && !halt_fault, "R5 breakpoint on last window edge", 32'(halted), 32'h1);
        tick(50);
        chk(!seen_req, "R5 no fetch after late breakpoint", 32'(seen_req), 32'h0);

        // Breakpoint one edge after the window
        do_reset(2);
        tick(WAIT_N); dbg_brk = 1; tick(1); dbg_brk = 0;
        wait_start("R5 breakpoint after window ignored");
        chk(!halted, "R5 no halt after window", 32'(halted), 32'h0);

        // Error on the stack pointer read
        err_sp = 1;
        do_reset(2); tick(120);
        chk(halted && halt_fault, "R8 error on first read", 32'(halt_fault), 32'h1);
        chk(!seen_start && !mem_req_valid, "R8 no start after first-read error", 32'(seen_start), 32'h0);
        err_sp = 0;

        // Error on the program counter read
        err_pc = 1;
        do_reset(2); tick(120);
        chk(halted && halt_fault, "R8 error on second read", 32'(halt_fault), 32'h1);
        chk(!seen_start, "R8 no start after second-read error", 32'(seen_start), 32'h0);
        err_pc = 0;

        // Fault during the window
        do_reset(2);
        tick(10); fault_in = 1; tick(1); fault_in = 0; tick(1);
        chk(halted && halt_fault, "R9 fault in window", 32'(halt_fault), 32'h1);
        tick(100);
        chk(!seen_req, "R9 no fetch after window fault", 32'(seen_req), 32'h0);

        // Reset while a read is outstanding
        lat = 20;
        do_reset(2);
        count_window("R4 window before abort");
        tick(5);
        lat = 0;
        rst = 1; tick(1); rst = 0;
        chk(!mem_req_valid && !halted && sp_out == 0, "R1 abort mid-read", 32'(mem_req_valid), 32'h0);
        count_window("R1 window restarts after abort");
        wait_start("R1 boot after abort");
        chk(sp_out == sp_word, "R1 stale response discarded", sp_out, sp_word);

        tick(5);
        finished = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule